// File: doc/BRIEF.md
# Global Cold/Warm Reset Sequencer

This block is the central reset controller of a chip. It accepts reset requests from several places and turns them into two kinds of reset. A cold reset comes from power-up (the controller's own `por_n`) or from an emulation request. It resets every module class, and it also drives a power-on reset line that only cold resets touch. A warm reset comes from a software request bit, a watchdog request or an external request pin. It resets every module class except a parameter-chosen set of preserved classes, such as the memory controller, I/O control, the 32 kHz sync timer, one PLL, the emulation logic and the fuse block. A module that needs to tell the two kinds apart uses both its class reset and its power-on reset.

A warm reset runs a fixed sequence of steps:

1. The internal warm reset is asserted.
2. One cycle later, the reset to the external modem interface is asserted.
3. One cycle after that, the active-low external warm-reset pin goes low for a programmable count.
4. A one-cycle abort is pulsed to the voltage-control serial bus.
5. A one-cycle power-on request is raised for every domain that is currently off.

The asynchronous requests are synchronised first. A cold request wins over anything in progress and restarts the controller in cold reset. A sticky cause register records why resets happened, and software clears its bits by writing ones. Each domain also has a simple local reset output. This output pulses when the domain leaves the off state, and it follows that domain's software reset bit.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_n` is low, and for COLD_CYC clock cycles after it rises, `cold_rst`, `warm_rst`, `modem_warm_rst`, every `cls_rst` bit and every `cls_pwron_rst` bit are high, and `ext_warm_rst_n` is low.
- R2: An `emu_cold_req` held for three cycles forces cold reset from any state, including mid-warm-sequence. The warm sequence is then abandoned and does not resume. Cause bit 0 becomes set.
- R3: A warm sequence starts from idle on any of three triggers: a `sw_rst_set` pulse (which sets `sw_rst_bit`), a `wdt_req` held for three cycles, or an `ext_req` held for three cycles.
- R4: In a warm sequence, `warm_rst` rises first. `modem_warm_rst` rises exactly one cycle later. `ext_warm_rst_n` falls exactly one cycle after that.
- R5: `ext_warm_rst_n` stays low for `hold_cfg` cycles. A `hold_cfg` of 0 counts as 1 cycle.
- R6: `vc_abort` is high for exactly one cycle per warm sequence, in the cycle right after the pin is released.
- R7: `dom_on_req` equals `dom_off` for the single cycle after the abort, and is zero at all other times.
- R8: During a warm reset, the `cls_rst` bits selected by PRESERVE stay low, and `cls_pwron_rst` stays low.
- R9: `rst_cause` bit 0 is cold, bit 1 software, bit 2 watchdog and bit 3 external. The bits are sticky, reset to 4'b0001, and are cleared by writing 1 to the same position of `cause_clr`.
- R10: `sw_rst_bit` clears itself when the warm sequence completes.
- R11: A `dom_rst` bit pulses for one cycle, one cycle after that domain's `dom_off` falls. It follows that domain's `dom_sw_rst` with a one-cycle delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| emu_cold_req | input | 1 | Emulation cold reset request, asynchronous |
| wdt_req | input | 1 | Watchdog warm reset request, asynchronous |
| ext_req | input | 1 | External warm reset request, asynchronous |
| sw_rst_set | input | 1 | Write pulse that sets the software warm reset bit |
| hold_cfg | input | 8 | External pin hold count in cycles |
| cause_clr | input | 4 | Write-one-to-clear strobes for the cause bits |
| dom_off | input | NDOM | Per-domain off status |
| dom_sw_rst | input | NDOM | Per-domain software local reset bits |
| cold_rst | output | 1 | Cold reset active |
| warm_rst | output | 1 | Internal warm reset (also high in cold) |
| cls_rst | output | NCLS | Per-class reset |
| cls_pwron_rst | output | NCLS | Per-class power-on reset (cold only) |
| modem_warm_rst | output | 1 | Reset to the external modem interface |
| ext_warm_rst_n | output | 1 | External warm reset pin, active low |
| vc_abort | output | 1 | Abort pulse to the voltage-control serial bus |
| dom_on_req | output | NDOM | Power-on request for domains found off |
| dom_rst | output | NDOM | Per-domain local reset |
| sw_rst_bit | output | 1 | Software warm reset bit |
| rst_cause | output | 4 | Sticky reset cause bits |

## Verification
The hardest situation to reach from the ports is a cold request landing in the middle of a warm sequence. To get there, the bench starts a watchdog warm reset with a long pin hold and waits until the pin is seen low. Only then does it raise the emulation request. It checks that cold reset takes over within the synchroniser latency, and that no part of the warm sequence resumes afterwards. Randomised runs cover the step spacing of every source, a pin hold count that varies with zero included, and mixes of off domains.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COLD,
    ST_WINT,
    ST_WMDM,
    ST_WPIN,
    ST_WABT,
    ST_WWAKE
  } seq_st_t;

  localparam int CZ_COLD = 0;
  localparam int CZ_SW   = 1;
  localparam int CZ_WDT  = 2;
  localparam int CZ_EXT  = 3;
  localparam int CZ_W    = 4;

  // Effective pin low time: a zero count is stretched to one cycle.
  function automatic logic [8:0] pin_len(input logic [7:0] h);
    return (h == 8'd0) ? 9'd1 : {1'b0, h};
  endfunction

endpackage

// File: rtl/rst_req_sync.sv
module rst_req_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_async;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int COLD_CYC = 4
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       cold_s,
  input  logic       sw_bit,
  input  logic       wdt_s,
  input  logic       ext_s,
  input  logic [7:0] hold_cfg,
  output seq_st_t    state,
  output logic       seq_start,
  output logic       seq_done
);

  localparam int CNT_W = $clog2((COLD_CYC > 512) ? COLD_CYC : 512);

  logic [CNT_W-1:0] cnt;
  logic [8:0]       hold_q;
  logic             any_warm;
  logic             cold_last;
  logic             pin_last;

  assign any_warm  = sw_bit | wdt_s | ext_s;
  assign cold_last = (cnt == CNT_W'(COLD_CYC - 1));
  assign pin_last  = (cnt == (CNT_W'(hold_q) - CNT_W'(1)));
  assign seq_start = (state == ST_IDLE) && !cold_s && any_warm;
  assign seq_done  = (state == ST_WWAKE) && !cold_s;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state  <= ST_COLD;
      cnt    <= '0;
      hold_q <= 9'd1;
    end else if (cold_s) begin
      state <= ST_COLD;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (any_warm) begin
            state  <= ST_WINT;
            hold_q <= pin_len(hold_cfg);
          end
        end
        ST_COLD: begin
          if (cold_last) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_WINT: state <= ST_WMDM;
        ST_WMDM: begin
          state <= ST_WPIN;
          cnt   <= '0;
        end
        ST_WPIN: begin
          if (pin_last) begin
            state <= ST_WABT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_WABT:  state <= ST_WWAKE;
        ST_WWAKE: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_seq_pkg::*;
(
  input  logic            clk,
  input  logic            por_n,
  input  logic            cold_evt,
  input  logic            seq_start,
  input  logic            sw_src,
  input  logic            wdt_src,
  input  logic            ext_src,
  input  logic [CZ_W-1:0] clr,
  output logic [CZ_W-1:0] cause
);

  logic [CZ_W-1:0] set_v;

  always_comb begin
    set_v          = '0;
    set_v[CZ_COLD] = cold_evt;
    set_v[CZ_SW]   = seq_start & sw_src;
    set_v[CZ_WDT]  = seq_start & wdt_src;
    set_v[CZ_EXT]  = seq_start & ext_src;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cause <= CZ_W'(1) << CZ_COLD;
    else        cause <= (cause & ~clr) | set_v;
  end

endmodule

// File: rtl/rst_dom_local.sv
module rst_dom_local #(
  parameter int NDOM = 4
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic [NDOM-1:0] dom_off,
  input  logic [NDOM-1:0] dom_sw_rst,
  output logic [NDOM-1:0] dom_rst
);

  logic [NDOM-1:0] off_q;

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        off_q[d]   <= 1'b0;
        dom_rst[d] <= 1'b0;
      end else begin
        off_q[d]   <= dom_off[d];
        dom_rst[d] <= (off_q[d] & ~dom_off[d]) | dom_sw_rst[d];
      end
    end
  end

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int              NCLS     = 8,
  parameter int              NDOM     = 4,
  parameter int              COLD_CYC = 4,
  parameter int              SYNC_STG = 2,
  parameter logic [NCLS-1:0] PRESERVE = 8'hF0
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            emu_cold_req,
  input  logic            wdt_req,
  input  logic            ext_req,
  input  logic            sw_rst_set,
  input  logic [7:0]      hold_cfg,
  input  logic [CZ_W-1:0] cause_clr,
  input  logic [NDOM-1:0] dom_off,
  input  logic [NDOM-1:0] dom_sw_rst,
  output logic            cold_rst,
  output logic            warm_rst,
  output logic [NCLS-1:0] cls_rst,
  output logic [NCLS-1:0] cls_pwron_rst,
  output logic            modem_warm_rst,
  output logic            ext_warm_rst_n,
  output logic            vc_abort,
  output logic [NDOM-1:0] dom_on_req,
  output logic [NDOM-1:0] dom_rst,
  output logic            sw_rst_bit,
  output logic [CZ_W-1:0] rst_cause
);

  logic [2:0] req_s;
  logic       cold_s, wdt_s, ext_s;
  seq_st_t    state;
  logic       seq_start, seq_done;
  logic       in_warm, in_mdm;

  rst_req_sync #(.W(3), .STAGES(SYNC_STG)) u_sync (
    .clk     (clk),
    .rst_n   (por_n),
    .d_async ({ext_req, wdt_req, emu_cold_req}),
    .q_sync  (req_s)
  );

  assign cold_s = req_s[0];
  assign wdt_s  = req_s[1];
  assign ext_s  = req_s[2];

  rst_seq_fsm #(.COLD_CYC(COLD_CYC)) u_fsm (
    .clk       (clk),
    .por_n     (por_n),
    .cold_s    (cold_s),
    .sw_bit    (sw_rst_bit),
    .wdt_s     (wdt_s),
    .ext_s     (ext_s),
    .hold_cfg  (hold_cfg),
    .state     (state),
    .seq_start (seq_start),
    .seq_done  (seq_done)
  );

  rst_cause_reg u_cause (
    .clk       (clk),
    .por_n     (por_n),
    .cold_evt  (cold_s),
    .seq_start (seq_start),
    .sw_src    (sw_rst_bit),
    .wdt_src   (wdt_s),
    .ext_src   (ext_s),
    .clr       (cause_clr),
    .cause     (rst_cause)
  );

  rst_dom_local #(.NDOM(NDOM)) u_local (
    .clk        (clk),
    .por_n      (por_n),
    .dom_off    (dom_off),
    .dom_sw_rst (dom_sw_rst),
    .dom_rst    (dom_rst)
  );

  // Software warm reset bit: a write sets it, completion clears it.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          sw_rst_bit <= 1'b0;
    else if (sw_rst_set) sw_rst_bit <= 1'b1;
    else if (seq_done)   sw_rst_bit <= 1'b0;
  end

  assign in_warm = (state inside {ST_WINT, ST_WMDM, ST_WPIN, ST_WABT, ST_WWAKE});
  assign in_mdm  = (state inside {ST_WMDM, ST_WPIN, ST_WABT, ST_WWAKE});

  assign cold_rst       = (state == ST_COLD);
  assign warm_rst       = cold_rst | in_warm;
  assign modem_warm_rst = cold_rst | in_mdm;
  assign ext_warm_rst_n = !(cold_rst || state == ST_WPIN);
  assign vc_abort       = (state == ST_WABT);
  assign dom_on_req     = (state == ST_WWAKE) ? dom_off : '0;

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    if (PRESERVE[c]) begin : g_keep
      assign cls_rst[c] = cold_rst;
    end else begin : g_plain
      assign cls_rst[c] = warm_rst;
    end
    assign cls_pwron_rst[c] = cold_rst;
  end

endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
  parameter int              NCLS     = 8,
  parameter int              NDOM     = 4,
  parameter logic [NCLS-1:0] PRESERVE = 8'hF0
) (
  input logic            clk,
  input logic            por_n,
  input logic            cold_rst,
  input logic            warm_rst,
  input logic [NCLS-1:0] cls_rst,
  input logic [NCLS-1:0] cls_pwron_rst,
  input logic            modem_warm_rst,
  input logic            ext_warm_rst_n,
  input logic            vc_abort,
  input logic [NDOM-1:0] dom_on_req,
  input logic [NDOM-1:0] dom_off,
  input logic            sw_rst_bit,
  input logic            sw_rst_set,
  input logic            seq_start,
  input logic            seq_done
);

  a_r1_cold_all: assert property (@(posedge clk) disable iff (!por_n)
    cold_rst |-> (&cls_rst && &cls_pwron_rst && modem_warm_rst && !ext_warm_rst_n));

  a_r8_pwron_cold_only: assert property (@(posedge clk) disable iff (!por_n)
    !cold_rst |-> (cls_pwron_rst == '0));

  a_r8_preserve: assert property (@(posedge clk) disable iff (!por_n)
    !cold_rst |-> ((cls_rst & PRESERVE) == '0));

  a_r4_internal_first: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(warm_rst) && !cold_rst) |-> (!modem_warm_rst && ext_warm_rst_n));

  a_r4_pin_inside: assert property (@(posedge clk) disable iff (!por_n)
    !ext_warm_rst_n |-> (warm_rst && modem_warm_rst));

  a_r6_abort_pulse: assert property (@(posedge clk) disable iff (!por_n)
    vc_abort |=> !vc_abort);

  a_r7_wake_subset: assert property (@(posedge clk) disable iff (!por_n)
    (dom_on_req & ~dom_off) == '0);

  a_r10_sw_clear: assert property (@(posedge clk) disable iff (!por_n)
    (seq_done && !sw_rst_set) |=> !sw_rst_bit);

  a_r4_done_release: assert property (@(posedge clk) disable iff (!por_n)
    seq_done |=> !modem_warm_rst);

  a_r3_start_step: assert property (@(posedge clk) disable iff (!por_n)
    seq_start |=> (warm_rst && !modem_warm_rst));

endmodule

bind rst_seq_ctrl rst_seq_chk #(
  .NCLS(NCLS), .NDOM(NDOM), .PRESERVE(PRESERVE)
) u_chk (
  .clk            (clk),
  .por_n          (por_n),
  .cold_rst       (cold_rst),
  .warm_rst       (warm_rst),
  .cls_rst        (cls_rst),
  .cls_pwron_rst  (cls_pwron_rst),
  .modem_warm_rst (modem_warm_rst),
  .ext_warm_rst_n (ext_warm_rst_n),
  .vc_abort       (vc_abort),
  .dom_on_req     (dom_on_req),
  .dom_off        (dom_off),
  .sw_rst_bit     (sw_rst_bit),
  .sw_rst_set     (sw_rst_set),
  .seq_start      (seq_start),
  .seq_done       (seq_done)
);

// File: tb/rst_seq_ctrl_test.sv
`timescale 1ns/1ps
module rst_seq_ctrl_test;

  localparam int NCLS = 8;
  localparam int NDOM = 4;
  localparam int COLD_CYC = 4;
  localparam logic [NCLS-1:0] PRES = 8'hF0;

  logic clk = 1'b0;
  logic por_n, emu_cold_req, wdt_req, ext_req, sw_rst_set;
  logic [7:0] hold_cfg;
  logic [3:0] cause_clr;
  logic [NDOM-1:0] dom_off, dom_sw_rst;
  logic cold_rst, warm_rst, modem_warm_rst, ext_warm_rst_n, vc_abort, sw_rst_bit;
  logic [NCLS-1:0] cls_rst, cls_pwron_rst;
  logic [NDOM-1:0] dom_on_req, dom_rst;
  logic [3:0] rst_cause;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  rst_seq_ctrl #(.NCLS(NCLS), .NDOM(NDOM), .COLD_CYC(COLD_CYC), .PRESERVE(PRES)) uut (
    .clk(clk), .por_n(por_n), .emu_cold_req(emu_cold_req), .wdt_req(wdt_req),
    .ext_req(ext_req), .sw_rst_set(sw_rst_set), .hold_cfg(hold_cfg),
    .cause_clr(cause_clr), .dom_off(dom_off), .dom_sw_rst(dom_sw_rst),
    .cold_rst(cold_rst), .warm_rst(warm_rst), .cls_rst(cls_rst),
    .cls_pwron_rst(cls_pwron_rst), .modem_warm_rst(modem_warm_rst),
    .ext_warm_rst_n(ext_warm_rst_n), .vc_abort(vc_abort), .dom_on_req(dom_on_req),
    .dom_rst(dom_rst), .sw_rst_bit(sw_rst_bit), .rst_cause(rst_cause)
  );

  function automatic int eff_hold(input int h);
    if (h < 1) return 1;
    return h;
  endfunction

  function automatic logic [3:0] cause_of(input int src);
    logic [3:0] v;
    v = 4'b0000;
    v[src + 1] = 1'b1;   // src 0 sw -> bit1, 1 wdt -> bit2, 2 ext -> bit3
    return v;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_warm(input int src, input logic [7:0] h, input logic [NDOM-1:0] doff);
    int tw, tm, tp, ta, tk, npin, nab, t;
    logic [NDOM-1:0] wake;
    bit leak_keep, leak_pwron;
    tw = -1; tm = -1; tp = -1; ta = -1; tk = -1; npin = 0; nab = 0;
    wake = '0; leak_keep = 0; leak_pwron = 0;
    @(negedge clk);
    cause_clr = 4'hF; hold_cfg = h; dom_off = doff;
    @(negedge clk);
    cause_clr = 4'h0;
    chk("R9 clear", rst_cause, 0);
    if (src == 0) begin
      sw_rst_set = 1'b1;
      @(negedge clk);
      sw_rst_set = 1'b0;
      chk("R3 sw bit set", sw_rst_bit, 1);
    end else if (src == 1) wdt_req = 1'b1;
    else ext_req = 1'b1;
    for (t = 0; t < 700; t++) begin
      if (t == 3) begin wdt_req = 1'b0; ext_req = 1'b0; end
      if (warm_rst && tw < 0) tw = t;
      if (modem_warm_rst && tm < 0) tm = t;
      if (!ext_warm_rst_n) begin if (tp < 0) tp = t; npin++; end
      if (vc_abort) begin if (ta < 0) ta = t; nab++; end
      if (dom_on_req != 0) begin if (tk < 0) tk = t; wake = dom_on_req; end
      if ((cls_rst & PRES) != 0) leak_keep = 1;
      if (cls_pwron_rst != 0) leak_pwron = 1;
      if (tw >= 0 && !warm_rst) break;
      @(negedge clk);
    end
    chk("R3 warm started", (tw >= 0), 1);
    chk("R4 modem one after internal", tm - tw, 1);
    chk("R4 pin one after modem", tp - tm, 1);
    chk("R5 pin low length", npin, eff_hold(int'(h)));
    chk("R6 abort right after pin", ta - tp, eff_hold(int'(h)));
    chk("R6 abort width", nab, 1);
    chk("R7 wake value", wake, doff);
    if (doff != 0) chk("R7 wake after abort", tk - ta, 1);
    chk("R8 preserved untouched", leak_keep, 0);
    chk("R8 pwron untouched", leak_pwron, 0);
    chk("R9 cause source", rst_cause, cause_of(src));
    chk("R10 sw bit clear", sw_rst_bit, 0);
    repeat (4) @(negedge clk);
    chk("R3 no restart", warm_rst, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int n, dummy;
    dummy = $urandom(32'h5eed);
    por_n = 1'b0; emu_cold_req = 1'b0; wdt_req = 1'b0; ext_req = 1'b0;
    sw_rst_set = 1'b0; hold_cfg = 8'd3; cause_clr = 4'h0;
    dom_off = '0; dom_sw_rst = '0;
    repeat (3) @(negedge clk);
    chk("R1 cold in por", cold_rst, 1);
    chk("R1 pwron all", cls_pwron_rst, {NCLS{1'b1}});
    chk("R1 class all", cls_rst, {NCLS{1'b1}});
    chk("R1 pin low", ext_warm_rst_n, 0);
    chk("R9 reset cause", rst_cause, 4'b0001);
    por_n = 1'b1;
    n = 0;
    while (cold_rst && n < 100) begin n++; @(negedge clk); end
    chk("R1 cold length", n, COLD_CYC);
    chk("R1 idle after cold", warm_rst, 0);

    // directed pin-hold corners
    run_warm(0, 8'd0, 4'b0101);
    run_warm(1, 8'd1, 4'b0000);
    run_warm(2, 8'd255, 4'b1111);

    // randomised runs
    for (int k = 0; k < 24; k++) begin
      run_warm(int'($urandom_range(0, 2)), 8'($urandom_range(0, 20)),
               NDOM'($urandom_range(0, 15)));
    end

    // R2: cold request in the middle of a warm pin stretch
    @(negedge clk);
    cause_clr = 4'hF; hold_cfg = 8'd40;
    @(negedge clk);
    cause_clr = 4'h0; wdt_req = 1'b1;
    n = 0;
    while (ext_warm_rst_n && n < 50) begin n++; @(negedge clk); end
    wdt_req = 1'b0;
    chk("R2 pin reached", ext_warm_rst_n, 0);
    repeat (5) @(negedge clk);
    emu_cold_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 cold takes over", cold_rst, 1);
    emu_cold_req = 1'b0;
    n = 0;
    while (cold_rst && n < 50) begin n++; @(negedge clk); end
    repeat (8) @(negedge clk);
    chk("R2 warm abandoned", warm_rst, 0);
    chk("R2 pin released", ext_warm_rst_n, 1);
    chk("R2 cause cold+wdt", rst_cause, 4'b0101);

    // R11: local domain resets
    dom_off = 4'b0010;
    repeat (3) @(negedge clk);
    chk("R11 quiet while off", dom_rst, 0);
    dom_off = 4'b0000;
    @(negedge clk);
    chk("R11 pulse on wake", dom_rst, 4'b0010);
    @(negedge clk);
    chk("R11 pulse ends", dom_rst, 0);
    dom_sw_rst = 4'b1000;
    @(negedge clk);
    chk("R11 sw local", dom_rst, 4'b1000);
    @(negedge clk);
    chk("R11 sw local held", dom_rst, 4'b1000);
    dom_sw_rst = 4'b0000;
    @(negedge clk);
    chk("R11 sw local release", dom_rst, 0);
    chk("R7 no wake when idle", dom_on_req, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule